// File: doc/BRIEF.md
# Memory Response Watchdog Counter

This block guards a memory that answers every access with a ready pulse. When an access begins, a down-counter is loaded with an 8-bit programmed limit and then counts one step per peripheral clock. A ready response reloads the counter with the limit. If the count reaches zero before any response, the counter freezes at zero and a sticky timeout flag is raised. The flag stays set until a clear strobe arrives.

A programmed limit of zero turns the watchdog off. When no access is outstanding the counter sits idle and keeps its value. The live count is available as an output, so software can see how much of the response window is left.

Top module: `mem_resp_watchdog`

## Requirements
- R1: When `acc_start` is high and `reload_cfg` is non-zero at a rising clock edge, `count_val` equals `reload_cfg` after that edge. It then drops by one at every following edge while no other event occurs.
- R2: When `mem_ready` is high at an edge, `count_val` equals `reload_cfg` after that edge. If `acc_start` is not high in the same cycle, the counter then stops counting.
- R3: If an armed count started from N gets no ready response, `count_val` reaches 0 at the N-th edge after the start edge. `timeout_flag` rises at that same edge. The count then stays at 0 until a start or a ready arrives.
- R4: `timeout_flag` stays high until a cycle with `flag_clr` high, and it is low after that edge. If an expiry and a clear fall in the same cycle, the expiry wins and the flag ends high.
- R5: The flag is set only once per expiry. After a clear, a counter that is still frozen at zero does not raise the flag again.
- R6: While `reload_cfg` is 0, `acc_start` is ignored. `count_val` keeps its value and the flag does not change.
- R7: With no access outstanding and no strobe, `count_val` does not change.
- R8: When `acc_start` (with a non-zero limit) and `mem_ready` are both high in one cycle, the counter reloads to `reload_cfg` and stays armed, so it decrements at the next edge.
- R9: `rst_n` is a synchronous active-low reset. At the edge where it is sampled low, `count_val` becomes 0 and `timeout_flag` becomes 0, and the counter goes idle.
- R10: An `acc_start` while the counter is frozen at zero re-arms it from `reload_cfg`. `timeout_flag` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | Strobe marking the start of a memory access |
| mem_ready | input | 1 | Memory completion response |
| reload_cfg | input | 8 | Programmed response window in clocks; 0 disables the watchdog |
| flag_clr | input | 1 | Strobe that clears the timeout flag |
| count_val | output | 8 | Live counter value |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
A wrong internal state shows up on `count_val` within one clock. A sequencer stuck idle would freeze the count right after a start, and a sequencer stuck armed would make the count drop after a ready. A wrong expiry decision shows at the edge where the count reaches zero: either the flag does not rise there, or the count wraps to 255 instead of holding. A faulty flag priority shows only when a clear and an expiry fall in the same cycle, so the bench lines these two up on purpose.

// File: rtl/mrw_pkg.sv
// Package: shared types for the memory response watchdog.
// Holds the sequencer state encoding and the counter operation code.
package mrw_pkg;

    // Sequencer state: waiting, counting a pending access, or frozen at zero.
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_t;

    // Operation the sequencer requests from the down-counter each cycle.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_t;

endpackage

// File: rtl/mrw_seq.sv
// Module: mrw_seq
// Decides each cycle whether the counter loads, decrements or holds.
// It tracks whether an access is outstanding and flags the single cycle
// in which the count runs out.
// Assumes: cnt_at_one is derived from the counter's current value.
// A ready response takes priority over counting, and a start with a
// zero limit is ignored.
module mrw_seq
    import mrw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acc_start,
    input  logic      mem_ready,
    input  logic      cfg_nonzero,
    input  logic      cnt_at_one,
    output wd_state_t state,
    output cnt_op_t   cnt_op,
    output logic      expire_pulse
);

    wd_state_t state_d;
    logic      arm_req;

    assign arm_req = acc_start & cfg_nonzero;

    // Next state and counter operation from the current state and the strobes.
    always_comb begin
        state_d      = state;
        cnt_op       = CNT_HOLD;
        expire_pulse = 1'b0;
        if (mem_ready) begin
            cnt_op  = CNT_LOAD;
            state_d = arm_req ? WD_ARMED : WD_IDLE;
        end else if (arm_req) begin
            cnt_op  = CNT_LOAD;
            state_d = WD_ARMED;
        end else begin
            case (state)
                WD_ARMED: begin
                    cnt_op = CNT_DEC;
                    if (cnt_at_one) begin
                        state_d      = WD_EXPIRED;
                        expire_pulse = 1'b1;
                    end
                end
                default: state_d = state;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_d;
    end

endmodule

// File: rtl/mrw_downcnt.sv
// Module: mrw_downcnt
// A down-counter register that loads, decrements or holds on command.
// Assumes: the sequencer never asks for a decrement at zero. The counter
// still saturates at zero so that it can never wrap.
module mrw_downcnt
    import mrw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_t          op,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             at_one
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign at_one = (count == ONE);

    // Count register: load the limit, step down toward zero, or keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case (op)
                CNT_LOAD: count <= load_val;
                CNT_DEC:  count <= (count == '0) ? count : count - ONE;
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/mrw_sticky.sv
// Module: mrw_sticky
// A sticky event flag: set by a one-cycle event, cleared by a strobe.
// Assumes: when set and clear arrive together, the set wins, so no
// expiry is lost.
module mrw_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/mem_resp_watchdog.sv
// Module: mem_resp_watchdog
// Watchdog for memory responses. Each access start arms a down-counter
// from reload_cfg, and each ready response reloads it. When the count
// reaches zero without a response, the counter freezes and a sticky
// flag is raised.
// Assumes: all inputs are synchronous to clk. A reload_cfg of zero
// disables the watchdog.
module mem_resp_watchdog
    import mrw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_start,
    input  logic             mem_ready,
    input  logic [CNT_W-1:0] reload_cfg,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count_val,
    output logic             timeout_flag
);

    wd_state_t st_q;
    cnt_op_t   op_w;
    logic      expire_w;
    logic      at_one_w;
    logic      cfg_nz_w;

    assign cfg_nz_w = |reload_cfg;

    mrw_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .mem_ready    (mem_ready),
        .cfg_nonzero  (cfg_nz_w),
        .cnt_at_one   (at_one_w),
        .state        (st_q),
        .cnt_op       (op_w),
        .expire_pulse (expire_w)
    );

    mrw_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_w),
        .load_val (reload_cfg),
        .count    (count_val),
        .at_one   (at_one_w)
    );

    mrw_sticky u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire_w),
        .clr_req (flag_clr),
        .flag    (timeout_flag)
    );

endmodule

// File: rtl/mrw_checker.sv
// Module: mrw_checker
// Property checks for mem_resp_watchdog, attached with bind.
// Assumes: it is connected to the top ports and to the sequencer state
// and expiry strobe.
module mrw_checker
    import mrw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_start,
    input logic             mem_ready,
    input logic [CNT_W-1:0] reload_cfg,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count_val,
    input logic             timeout_flag,
    input wd_state_t        st,
    input logic             expire
);

    // R1: a start with a non-zero limit loads that limit.
    a_r1_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && reload_cfg != '0 && !mem_ready) |=> count_val == $past(reload_cfg));

    // R1: an armed counter with no strobe steps down by one.
    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_ARMED && !acc_start && !mem_ready) |=> count_val == $past(count_val) - 1'b1);

    // R2: a ready response reloads the limit.
    a_r2_ready_reload: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> count_val == $past(reload_cfg));

    // R3: a count of zero stays at zero without a strobe.
    a_r3_freeze_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count_val == '0 && !acc_start && !mem_ready) |=> count_val == '0);

    // R3: the flag rises only together with a zero count.
    a_r3_flag_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> count_val == '0);

    // R4: the flag holds without a clear.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !flag_clr) |=> timeout_flag);

    // R4: a clear without a coinciding expiry drops the flag.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !expire) |=> !timeout_flag);

    // R6: a start with a zero limit and no ready leaves the count as it was.
    a_r6_zero_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && reload_cfg == '0 && !mem_ready && st != WD_ARMED) |=> $stable(count_val));

    // R7: an idle counter with no strobe keeps its value.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_IDLE && !acc_start && !mem_ready) |=> $stable(count_val));

endmodule

bind mem_resp_watchdog mrw_checker #(.CNT_W(CNT_W)) u_mrw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_start    (acc_start),
    .mem_ready    (mem_ready),
    .reload_cfg   (reload_cfg),
    .flag_clr     (flag_clr),
    .count_val    (count_val),
    .timeout_flag (timeout_flag),
    .st           (st_q),
    .expire       (expire_w)
);

// File: tb/test_mem_resp_watchdog.sv
// Directed bench for mem_resp_watchdog. Inputs are driven and outputs are
// sampled at falling edges, half a clock away from the active edge.
module test_mem_resp_watchdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 1'b0;
    logic       mem_ready = 1'b0;
    logic [7:0] reload_cfg = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] count_val;
    logic       timeout_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    mem_resp_watchdog i_mem_resp_watchdog (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .mem_ready    (mem_ready),
        .reload_cfg   (reload_cfg),
        .flag_clr     (flag_clr),
        .count_val    (count_val),
        .timeout_flag (timeout_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle strobes, applied over a single edge.
    task automatic pulse_start();
        acc_start = 1'b1; tick(1); acc_start = 1'b0;
    endtask

    task automatic pulse_ready();
        mem_ready = 1'b1; tick(1); mem_ready = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(2);
        check("R9 count after reset", count_val, 0);
        check("R9 flag after reset", timeout_flag, 0);
        rst_n = 1'b1; tick(1);
    endtask

    task automatic t_arm_expire();
        reload_cfg = 8'd5;
        pulse_start();
        check("R1 loaded", count_val, 5);
        tick(1);
        check("R1 decrement", count_val, 4);
        tick(3);
        check("R3 count one before expiry", count_val, 1);
        check("R3 flag low before expiry", timeout_flag, 0);
        tick(1);
        check("R3 count zero at expiry", count_val, 0);
        check("R3 flag at expiry", timeout_flag, 1);
        tick(3);
        check("R3 frozen at zero", count_val, 0);
    endtask

    task automatic t_sticky_clear();
        tick(2);
        check("R4 flag sticky", timeout_flag, 1);
        pulse_clr();
        check("R4 flag cleared", timeout_flag, 0);
        tick(5);
        check("R5 no second set", timeout_flag, 0);
        check("R5 still frozen", count_val, 0);
    endtask

    task automatic t_ready_idle();
        reload_cfg = 8'd10;
        pulse_start();
        tick(3);
        check("R1 count 7", count_val, 7);
        pulse_ready();
        check("R2 ready reload", count_val, 10);
        tick(4);
        check("R7 idle hold", count_val, 10);
        check("R2 no flag", timeout_flag, 0);
    endtask

    task automatic t_start_and_ready();
        reload_cfg = 8'd6;
        pulse_start();
        tick(2);
        check("R8 count before", count_val, 4);
        acc_start = 1'b1; mem_ready = 1'b1; tick(1);
        acc_start = 1'b0; mem_ready = 1'b0;
        check("R8 reload", count_val, 6);
        tick(1);
        check("R8 still armed", count_val, 5);
        pulse_ready();
        check("R2 back to idle", count_val, 6);
    endtask

    task automatic t_cfg_zero();
        reload_cfg = 8'd9;
        pulse_ready();
        check("R2 ready loads 9", count_val, 9);
        reload_cfg = 8'd0;
        pulse_start();
        tick(4);
        check("R6 zero cfg ignored", count_val, 9);
        check("R6 no flag", timeout_flag, 0);
    endtask

    task automatic t_set_clear_same();
        reload_cfg = 8'd2;
        pulse_start();
        check("R1 loaded 2", count_val, 2);
        tick(1);
        check("R1 count 1", count_val, 1);
        pulse_clr();
        check("R4 expiry beats clear", timeout_flag, 1);
        check("R3 zero", count_val, 0);
    endtask

    task automatic t_rearm();
        reload_cfg = 8'd4;
        pulse_start();
        check("R10 rearm load", count_val, 4);
        check("R10 flag kept", timeout_flag, 1);
        tick(1);
        check("R10 counting", count_val, 3);
        pulse_ready();
        check("R2 reload 4", count_val, 4);
    endtask

    task automatic t_reset_mid();
        pulse_start();
        tick(1);
        rst_n = 1'b0; tick(1); rst_n = 1'b1;
        check("R9 count cleared", count_val, 0);
        check("R9 flag cleared", timeout_flag, 0);
        tick(6);
        check("R9 idle after reset", count_val, 0);
        check("R9 no flag later", timeout_flag, 0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_arm_expire();
        t_sticky_clear();
        t_ready_idle();
        t_start_and_ready();
        t_cfg_zero();
        t_set_clear_same();
        t_rearm();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: end a hung run as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule